// File: doc/BRIEF.md
# Handshaked Multi-Cycle Byte ALU

This block takes two unsigned bytes and a three-bit operation code, and returns a 16-bit result through a level-held request/acknowledge handshake. The requester raises `start` with the operands and the code and keeps all of them steady. The unit answers with a one-cycle `done` pulse, and `result` is valid in that cycle. The requester then captures the result and lowers `start`.

The supported operations are addition, bitwise AND, bitwise XOR and multiplication. Addition and the two logic operations answer in one cycle. Multiplication takes several cycles, and the inputs are ignored while it runs.

The idle code 3'b000 and the spare codes 3'b101 to 3'b111 are one-cycle pulses that never produce `done`. A command that does produce `done` is taken only on a cycle where `start` is high after `start` has been low, or after an idle pulse. A `start` that stays high while the requester waits belongs to the command already taken.

Top module: `alu_hs_unit`

## Requirements
- R1: While `reset_n` is low, `done` is 0 and `result` is 16'h0000, including when reset arrives in the middle of a multiply. After reset, the next rising `start` is taken as a new command.
- R2: Code 3'b001 returns the zero-extended sum of the two operands, with the carry in bit 8.
- R3: Code 3'b010 returns the bitwise AND of the operands in bits 7:0, with bits 15:8 at zero.
- R4: Code 3'b011 returns the bitwise XOR of the operands in bits 7:0, with bits 15:8 at zero.
- R5: Code 3'b100 returns the full 16-bit unsigned product. With `MUL_LAT` = 3, `done` is high at the third rising edge counted from the edge that takes the command.
- R6: For codes 3'b001, 3'b010 and 3'b011, `done` is high at the rising edge right after the edge that takes the command.
- R7: `done` is high for exactly one cycle per command.
- R8: Codes 3'b000, 3'b101, 3'b110 and 3'b111 never raise `done`. If `start` stays high after one of these codes and the code changes to a working one, that working command is taken on the next edge.
- R9: After a working command is taken, `start` held high is not a new command, whatever `opcode` and operands show. Only one low cycle of `start` is needed before the next command.
- R10: While a multiply is in progress, `start`, `opcode` and the operands are ignored, including a low-then-high toggle of `start`. The multiply result is still the product of the operands captured when it was taken.
- R11: `result` keeps its value in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| reset_n | input | 1 | Asynchronous active-low reset |
| op_a | input | OPND_W | First unsigned operand |
| op_b | input | OPND_W | Second unsigned operand |
| opcode | input | 3 | Operation code |
| start | input | 1 | Request, held high until `done` is seen |
| done | output | 1 | One-cycle acknowledge; `result` is valid in this cycle |
| result | output | 2*OPND_W | Result of the most recent command |

## Verification
The bench builds the unit with its default parameters: 8-bit operands and a multiply latency of three cycles. With these values the operand corner values 8'h00 and 8'hFF can be enumerated by hand. The full-width product FE01 and the carry into bit 8 appear in the expected-value table.

A three-cycle latency leaves two busy cycles. That is enough room to toggle `start` low and high inside a multiply and show that the toggle is ignored. Back-to-back commands are driven with exactly one low cycle of `start` between them, so the re-arming rule is exercised at its minimum spacing.

// File: rtl/alu_hs_pkg.sv
package alu_hs_pkg;

  localparam int OPC_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_IDLE = 3'b000,
    OPC_SUM  = 3'b001,
    OPC_AND  = 3'b010,
    OPC_XOR  = 3'b011,
    OPC_MUL  = 3'b100
  } opc_e;

  // Single-cycle operations.
  function automatic logic opc_is_quick(input logic [OPC_W-1:0] c);
    return (c == OPC_SUM) || (c == OPC_AND) || (c == OPC_XOR);
  endfunction

  function automatic logic opc_is_mul(input logic [OPC_W-1:0] c);
    return c == OPC_MUL;
  endfunction

endpackage

// File: rtl/alu_cmd_gate.sv
// Decides on which cycle a request is taken as a new command.
module alu_cmd_gate
  import alu_hs_pkg::*;
(
  input  logic             clk,
  input  logic             reset_n,
  input  logic             start,
  input  logic             busy,
  input  logic [OPC_W-1:0] opcode,
  output logic             acc_quick,
  acc_mul
);
  logic armed;
  logic take;
  logic take_work;

  assign take      = start & armed & ~busy;
  assign acc_quick = take & opc_is_quick(opcode);
  assign acc_mul   = take & opc_is_mul(opcode);
  assign take_work = acc_quick | acc_mul;

  // Idle and spare codes leave the gate armed. A working command disarms it
  // until start is seen low. Nothing changes while a multiply runs.
  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n)      armed <= 1'b1;
    else if (!busy) begin
      if (take_work)   armed <= 1'b0;
      else if (!start) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/alu_quick_path.sv
// Single-cycle arithmetic and logic, combinational.
module alu_quick_path
  import alu_hs_pkg::*;
#(
  parameter int OPND_W = 8,
  localparam int RES_W = 2 * OPND_W
) (
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  input  logic [OPC_W-1:0]  opcode,
  output logic [RES_W-1:0]  quick_res
);
  function automatic logic [RES_W-1:0] f_sum(input logic [OPND_W-1:0] a, b);
    return {{OPND_W{1'b0}}, a} + {{OPND_W{1'b0}}, b};
  endfunction

  function automatic logic [RES_W-1:0] f_and(input logic [OPND_W-1:0] a, b);
    return {{OPND_W{1'b0}}, a & b};
  endfunction

  function automatic logic [RES_W-1:0] f_xor(input logic [OPND_W-1:0] a, b);
    return {{OPND_W{1'b0}}, a ^ b};
  endfunction

  always_comb begin
    unique case (opcode)
      OPC_SUM: quick_res = f_sum(op_a, op_b);
      OPC_AND: quick_res = f_and(op_a, op_b);
      OPC_XOR: quick_res = f_xor(op_a, op_b);
      default: quick_res = '0;
    endcase
  end
endmodule

// File: rtl/alu_mul_seq.sv
// Multiply with a multi-cycle path: the operands are held in registers
// and the product is sampled MUL_LAT-1 cycles after load.
module alu_mul_seq #(
  parameter int OPND_W  = 8,
  parameter int MUL_LAT = 3,  // must be at least 2
  localparam int RES_W  = 2 * OPND_W,
  localparam int CNT_W  = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1
) (
  input  logic              clk,
  input  logic              reset_n,
  input  logic              load,
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  output logic              busy,
  output logic              fin,
  output logic [RES_W-1:0]  prod
);
  logic [OPND_W-1:0] a_q, b_q;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [RES_W-1:0] f_prod(input logic [OPND_W-1:0] a, b);
    return {{OPND_W{1'b0}}, a} * {{OPND_W{1'b0}}, b};
  endfunction

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      cnt <= '0;
      a_q <= '0;
      b_q <= '0;
    end else if (load) begin
      cnt <= CNT_W'(MUL_LAT - 1);
      a_q <= op_a;
      b_q <= op_b;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
  assign fin  = (cnt == CNT_W'(1));
  assign prod = f_prod(a_q, b_q);
endmodule

// File: rtl/alu_hs_unit.sv
module alu_hs_unit
  import alu_hs_pkg::*;
#(
  parameter int OPND_W  = 8,
  parameter int MUL_LAT = 3,
  localparam int RES_W  = 2 * OPND_W
) (
  input  logic              clk,
  input  logic              reset_n,
  input  logic [OPND_W-1:0] op_a,
  input  logic [OPND_W-1:0] op_b,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              start,
  output logic              done,
  output logic [RES_W-1:0]  result
);
  // Named internal events, also used by the bound checker.
  logic             acc_quick;
  logic             acc_mul;
  logic             mul_busy;
  logic             mul_fin;
  logic [RES_W-1:0] quick_res;
  logic [RES_W-1:0] mul_prod;

  alu_cmd_gate u_gate (
    .clk       (clk),
    .reset_n   (reset_n),
    .start     (start),
    .busy      (mul_busy),
    .opcode    (opcode),
    .acc_quick (acc_quick),
    .acc_mul   (acc_mul)
  );

  alu_quick_path #(.OPND_W(OPND_W)) u_quick (
    .op_a      (op_a),
    .op_b      (op_b),
    .opcode    (opcode),
    .quick_res (quick_res)
  );

  alu_mul_seq #(.OPND_W(OPND_W), .MUL_LAT(MUL_LAT)) u_mul (
    .clk     (clk),
    .reset_n (reset_n),
    .load    (acc_mul),
    .op_a    (op_a),
    .op_b    (op_b),
    .busy    (mul_busy),
    .fin     (mul_fin),
    .prod    (mul_prod)
  );

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      done   <= 1'b0;
      result <= '0;
    end else begin
      done <= acc_quick | mul_fin;
      if (acc_quick)    result <= quick_res;
      else if (mul_fin) result <= mul_prod;
    end
  end
endmodule

// File: rtl/alu_hs_checker.sv
module alu_hs_checker
  import alu_hs_pkg::*;
#(
  parameter int OPND_W  = 8,
  parameter int MUL_LAT = 3,
  localparam int RES_W  = 2 * OPND_W,
  localparam int CW     = $clog2(MUL_LAT + 1)
) (
  input logic              clk,
  input logic              reset_n,
  input logic [OPND_W-1:0] op_a,
  input logic [OPND_W-1:0] op_b,
  input logic [OPC_W-1:0]  opcode,
  input logic              done,
  input logic [RES_W-1:0]  result,
  input logic              acc_quick,
  input logic              acc_mul,
  input logic              mul_busy
);
  localparam logic [OPND_W-1:0] ZB = '0;

  // Counts down from the taking of a multiply to its expected done.
  logic [CW-1:0]     wait_cnt;
  logic [RES_W-1:0]  exp_prod;

  always_ff @(posedge clk or negedge reset_n) begin
    if (!reset_n) begin
      wait_cnt <= '0;
      exp_prod <= '0;
    end else if (acc_mul) begin
      wait_cnt <= CW'(MUL_LAT);
      exp_prod <= {ZB, op_a} * {ZB, op_b};
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !reset_n |=> (!done && result == '0));

  a_r2_sum_value: assert property (@(posedge clk) disable iff (!reset_n)
    (acc_quick && opcode == OPC_SUM) |=>
      result == ({ZB, $past(op_a)} + {ZB, $past(op_b)}));

  a_r3_and_value: assert property (@(posedge clk) disable iff (!reset_n)
    (acc_quick && opcode == OPC_AND) |=> result == {ZB, $past(op_a) & $past(op_b)});

  a_r4_xor_value: assert property (@(posedge clk) disable iff (!reset_n)
    (acc_quick && opcode == OPC_XOR) |=> result == {ZB, $past(op_a) ^ $past(op_b)});

  a_r5_mul_latency: assert property (@(posedge clk) disable iff (!reset_n)
    (wait_cnt == CW'(1)) |-> (done && result == exp_prod));

  a_r6_quick_latency: assert property (@(posedge clk) disable iff (!reset_n)
    acc_quick |=> done);

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!reset_n)
    done |=> !done);

  a_r8_no_done_without_cmd: assert property (@(posedge clk) disable iff (!reset_n)
    (!mul_busy && !acc_quick && !acc_mul) |=> !done);

  a_r9_one_take_per_hold: assert property (@(posedge clk) disable iff (!reset_n)
    (acc_quick || acc_mul) |=> !(acc_quick || acc_mul));

  a_r10_busy_ignores: assert property (@(posedge clk) disable iff (!reset_n)
    mul_busy |-> !(acc_quick || acc_mul));

  a_r11_result_hold: assert property (@(posedge clk) disable iff (!reset_n)
    !done |-> $stable(result));
endmodule

bind alu_hs_unit alu_hs_checker #(.OPND_W(OPND_W), .MUL_LAT(MUL_LAT)) u_chk (
  .clk       (clk),
  .reset_n   (reset_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .opcode    (opcode),
  .done      (done),
  .result    (result),
  .acc_quick (acc_quick),
  .acc_mul   (acc_mul),
  .mul_busy  (mul_busy)
);

// File: tb/tb_alu_hs_unit.sv
`timescale 1ns/1ps
module tb_alu_hs_unit;
  localparam logic [2:0] C_IDLE = 3'b000, C_SUM = 3'b001, C_AND = 3'b010,
                         C_XOR  = 3'b011, C_MUL = 3'b100;
  localparam int NV = 15;
  // {opcode, a, b, expected}
  localparam logic [34:0] VEC [NV] = '{
    {C_SUM, 8'h00, 8'h00, 16'h0000},
    {C_SUM, 8'hFF, 8'hFF, 16'h01FE},
    {C_SUM, 8'hFF, 8'h01, 16'h0100},
    {C_SUM, 8'h12, 8'h34, 16'h0046},
    {C_AND, 8'hFF, 8'h0F, 16'h000F},
    {C_AND, 8'hA5, 8'h5A, 16'h0000},
    {C_AND, 8'hFF, 8'hFF, 16'h00FF},
    {C_XOR, 8'hFF, 8'h00, 16'h00FF},
    {C_XOR, 8'hA5, 8'hFF, 16'h005A},
    {C_XOR, 8'h3C, 8'h3C, 16'h0000},
    {C_MUL, 8'hFF, 8'hFF, 16'hFE01},
    {C_MUL, 8'h00, 8'hFF, 16'h0000},
    {C_MUL, 8'h10, 8'h10, 16'h0100},
    {C_MUL, 8'h0D, 8'h0B, 16'h008F},
    {C_MUL, 8'h01, 8'hFF, 16'h00FF}
  };

  logic        clk = 1'b0;
  logic        reset_n = 1'b0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [2:0]  opcode = '0;
  logic        start = 1'b0;
  logic        done;
  logic [15:0] result;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  alu_hs_unit dut (
    .clk(clk), .reset_n(reset_n), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .start(start), .done(done), .result(result)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One full handshake; start held until done, then one low cycle.
  task automatic issue(input logic [2:0] c, input logic [7:0] a, input logic [7:0] b,
                       output logic [15:0] res, output int lat);
    bit got = 0;
    @(negedge clk);
    opcode = c; op_a = a; op_b = b; start = 1'b1;
    lat = 0;
    while (!got && lat < 20) begin
      @(posedge clk); #1;
      lat++;
      if (done) got = 1;
    end
    res = result;
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    chk("R7 done single pulse", {31'b0, done}, 32'd0);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0] r;
    int lat;
    bit seen;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset done", {31'b0, done}, 32'd0);
    chk("R1 reset result", {16'b0, result}, 32'd0);
    @(negedge clk) reset_n = 1'b1;

    // Table walk: values (R2 R3 R4 R5), latencies (R5 R6), one low cycle between (R9)
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][34:32], VEC[i][31:24], VEC[i][23:16], r, lat);
      case (VEC[i][34:32])
        C_SUM: chk("R2 sum value", {16'b0, r}, {16'b0, VEC[i][15:0]});
        C_AND: chk("R3 and value", {16'b0, r}, {16'b0, VEC[i][15:0]});
        C_XOR: chk("R4 xor value", {16'b0, r}, {16'b0, VEC[i][15:0]});
        default: chk("R5 product value", {16'b0, r}, {16'b0, VEC[i][15:0]});
      endcase
      if (VEC[i][34:32] == C_MUL) chk("R5 multiply latency", lat, 32'd3);
      else                        chk("R6 quick latency", lat, 32'd1);
    end

    // R8: idle pulse gives no done; start held, working code taken next edge
    @(negedge clk);
    opcode = C_IDLE; op_a = 8'h20; op_b = 8'h05; start = 1'b1;
    @(posedge clk); #1;
    chk("R8 idle no done", {31'b0, done}, 32'd0);
    @(negedge clk) opcode = C_SUM;
    @(posedge clk); #1;
    chk("R8 command after idle done", {31'b0, done}, 32'd1);
    chk("R8 command after idle result", {16'b0, result}, 32'h25);
    @(negedge clk) start = 1'b0;
    @(posedge clk);

    // R8: spare codes never raise done; R11 result holds
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      opcode = 3'(c); op_a = 8'hFF; op_b = 8'hFF; start = 1'b1;
      @(negedge clk) start = 1'b0;
      seen = 0;
      repeat (4) begin
        @(posedge clk); #1;
        if (done) seen = 1;
      end
      chk("R8 spare code no done", {31'b0, seen}, 32'd0);
      chk("R11 result held", {16'b0, result}, 32'h25);
    end

    // R9: start held after a taken command is not a new command
    @(negedge clk);
    opcode = C_SUM; op_a = 8'h01; op_b = 8'h02; start = 1'b1;
    @(posedge clk); #1;
    chk("R9 first done", {31'b0, done}, 32'd1);
    @(negedge clk) begin opcode = C_XOR; op_a = 8'hFF; op_b = 8'h00; end
    seen = 0;
    repeat (4) begin
      @(posedge clk); #1;
      if (done) seen = 1;
    end
    chk("R9 held start no done", {31'b0, seen}, 32'd0);
    chk("R9 result unchanged", {16'b0, result}, 32'h3);
    @(negedge clk) start = 1'b0;
    @(posedge clk);

    // R10: toggle of start during a multiply is ignored
    @(negedge clk);
    opcode = C_MUL; op_a = 8'h0F; op_b = 8'h11; start = 1'b1;
    @(posedge clk); #1;
    chk("R10 no early done", {31'b0, done}, 32'd0);
    @(negedge clk) start = 1'b0;
    @(posedge clk); #1;
    chk("R10 no done while busy", {31'b0, done}, 32'd0);
    @(negedge clk) begin start = 1'b1; opcode = C_SUM; op_a = 8'h01; op_b = 8'h01; end
    @(posedge clk); #1;
    chk("R10 multiply done", {31'b0, done}, 32'd1);
    chk("R10 captured product", {16'b0, result}, 32'h00FF);
    seen = 0;
    repeat (3) begin
      @(posedge clk); #1;
      if (done) seen = 1;
    end
    chk("R10 toggle not taken", {31'b0, seen}, 32'd0);
    chk("R10 result still product", {16'b0, result}, 32'h00FF);
    @(negedge clk) start = 1'b0;
    @(posedge clk);

    // R1: reset in the middle of a multiply
    @(negedge clk);
    opcode = C_MUL; op_a = 8'hFF; op_b = 8'hFF; start = 1'b1;
    @(posedge clk);
    @(negedge clk) begin reset_n = 1'b0; start = 1'b0; end
    repeat (2) @(posedge clk);
    #1;
    chk("R1 mid-run reset done", {31'b0, done}, 32'd0);
    chk("R1 mid-run reset result", {16'b0, result}, 32'd0);
    @(negedge clk) reset_n = 1'b1;
    seen = 0;
    repeat (4) begin
      @(posedge clk); #1;
      if (done) seen = 1;
    end
    chk("R1 no done after reset", {31'b0, seen}, 32'd0);
    issue(C_AND, 8'hF0, 8'h3C, r, lat);
    chk("R1 command after reset", {16'b0, r}, 32'h0030);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule